// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire management bus that configures external Ethernet PHYs. A host writes a small set of 32-bit words to choose the frame flavour (the short-address format with start code 01, or the extended format with start code 00) and the clock divider. The host then fills in the PHY and register or device addresses and starts a transfer by writing one particular word. The block generates the management clock and serializes the frame onto the data line, which it drives through separate output and output-enable pins. During a read it releases the line from the turnaround onward. It captures the returned 16 bits and flags an error when no PHY pulls the second turnaround bit low.

Three writes start a transfer. Writing the data word starts a write frame. Writing the control word with its read bit set starts a read frame. Writing the address word while the extended format is selected starts an address frame. A busy bit in the status word covers every frame. A second busy bit, bit 31 of the data word, covers only data transfers. Any register write that arrives while a frame is running is dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset every register word reads as zero, `mdc` is low and `mdioOe` is low.
- R2: With divider field D in status bits 15:8, one `mdc` period is 4·D system clocks, and never fewer than 4. `mdc` idles low. `mdioOut` changes only on a falling `mdc` edge.
- R3: When status bit 6 is clear, a frame is built as follows, sent MSB first. It starts with 32 ones, which are omitted when control bit 10 is set. Then come start code 01 and an opcode: 01 for write, 10 for read. Next come the PHY address (control bits 9:5), the register address (control bits 4:0), turnaround 10 and the 16 data bits.
- R4: When status bit 6 is set, the frame has the same layout but uses start code 00. The opcode is 00 for an address frame, 01 for a write and 11 for a read.
- R5: A write frame starts when word 14 is written, and word 14 keeps the written data. A read frame starts when word 13 is written with bit 15 set. An address frame starts when word 15 is written with status bit 6 set. With bit 6 clear, a write to word 15 only stores the value.
- R6: During a read, `mdioOe` is low from the first turnaround bit to the end of the frame. At completion, the bits sampled on the last 16 rising `mdc` edges appear in word 14 bits 15:0.
- R7: During a read, a high level sampled on the second turnaround bit sets status bit 1. That bit clears when the next read starts.
- R8: Status bit 0 is high from the cycle after a frame starts until it ends. Word 14 bit 31 is high over the same span for read and write frames, but not for address frames.
- R9: A register write accepted on a clock edge while a frame is active, including the edge on which the frame ends, changes no register and starts no frame.
- R10: Control bits 11 and 14 are stored and read back but do not alter any frame.
- R11: The registers sit at word addresses 12 (status), 13 (control), 14 (data) and 15 (address). Every other word address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Word address for reads and writes |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for `regAddr`, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input value |

## Verification
Two functions can fall in the same clock edge: the serializer ending a frame on its last falling `mdc` edge, and the host presenting a new start command. The bench counts the exact frame length from the divider and the preamble setting. It places a data-word write precisely on the edge where the frame ends. It then judges the result at the ports: the busy bit must have been high just before that edge, the data word must hold the old value, and no second frame may appear on `mdc`. A write made one cycle later must start a frame. Random mixes of format, divider, preamble and PHY response are checked bit by bit against frames computed in the bench.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_AW     = 4;
  localparam int FRAME_BITS = 32;
  localparam int DATA_W     = 16;
  localparam int TA_POS     = 14;                         // first turnaround bit in frame
  localparam int RX_TA2     = FRAME_BITS - 1 - (TA_POS + 1); // captured second TA bit

  localparam logic [REG_AW-1:0] W_STAT = 4'd12;
  localparam logic [REG_AW-1:0] W_CTL  = 4'd13;
  localparam logic [REG_AW-1:0] W_DATA = 4'd14;
  localparam logic [REG_AW-1:0] W_ADDR = 4'd15;

  localparam int BUSY_BIT   = 0;
  localparam int RDERR_BIT  = 1;
  localparam int ENC_BIT    = 6;
  localparam int DIV_LSB    = 8;
  localparam int CTL_PREOFF = 10;
  localparam int CTL_RD     = 15;
  localparam int DATA_BUSY  = 31;

  typedef enum logic [1:0] {OP_NONE, OP_ADDR, OP_WRITE, OP_READ} opKind_t;

  typedef struct packed {
    logic                  launch;
    logic [FRAME_BITS-1:0] frame;
    logic                  preamble;
    logic                  isRead;
    logic                  isAddr;
  } mdioCmd_t;
endpackage

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mdioCmd_t              cmd,
  input  logic [DIV_W-1:0]      divField,
  input  logic                  mdioIn,
  output logic                  mdc,
  output logic                  mdioOut,
  output logic                  mdioOe,
  output logic                  active,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rxWord
);
  localparam int CNT_W   = DIV_W + 1;
  localparam int PRE_W   = $clog2(PRE_LEN + 1);
  localparam int BIT_W   = $clog2(FRAME_BITS + 1);
  localparam int TA_LEFT = FRAME_BITS - TA_POS;

  logic [CNT_W-1:0]      divCnt, halfPer;
  logic [PRE_W-1:0]      preCnt;
  logic [BIT_W-1:0]      bitsLeft;
  logic [FRAME_BITS-1:0] shReg;
  logic                  capBit, isRead, tick, inPre;
  logic                  unusedCmd;

  assign unusedCmd = cmd.isAddr;
  assign halfPer   = (divField == '0) ? CNT_W'(2) : {divField, 1'b0};
  assign tick      = active && (divCnt == halfPer - CNT_W'(1));
  assign inPre     = (preCnt != '0);
  assign mdioOut   = inPre ? 1'b1 : shReg[FRAME_BITS-1];
  assign mdioOe    = active && !(isRead && !inPre && (bitsLeft <= BIT_W'(TA_LEFT)));
  assign done      = tick && mdc && !inPre && (bitsLeft == BIT_W'(1));
  assign rxWord    = {shReg[FRAME_BITS-2:0], capBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      mdc      <= 1'b0;
      divCnt   <= '0;
      preCnt   <= '0;
      bitsLeft <= '0;
      shReg    <= '0;
      isRead   <= 1'b0;
      capBit   <= 1'b1;
    end else if (cmd.launch) begin
      active   <= 1'b1;
      mdc      <= 1'b0;
      divCnt   <= '0;
      preCnt   <= cmd.preamble ? PRE_W'(PRE_LEN) : '0;
      bitsLeft <= BIT_W'(FRAME_BITS);
      shReg    <= cmd.frame;
      isRead   <= cmd.isRead;
      capBit   <= 1'b1;
    end else if (active) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (!mdc) begin
          capBit <= mdioIn;                 // rising edge: sample line
        end else if (inPre) begin
          preCnt <= preCnt - PRE_W'(1);     // falling edge inside preamble
        end else begin
          shReg    <= rxWord;               // falling edge: next frame bit
          bitsLeft <= bitsLeft - BIT_W'(1);
          if (bitsLeft == BIT_W'(1)) active <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  // R2: clock parks low between frames
  p_mdc_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !mdc);
  // R2: data line holds while mdc stays high
  p_mdio_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (active && mdc && $past(mdc)) |-> $stable(mdioOut));
  // R8: completion drops the frame
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !active);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [31:0]           regWData,
  output logic [31:0]           regRData,
  input  logic                  active,
  input  logic                  done,
  input  logic [FRAME_BITS-1:0] rxWord,
  output mdioCmd_t              cmd,
  output logic [DIV_W-1:0]      divField
);
  logic              encSel, rdErr;
  logic [DIV_W-1:0]  divReg;
  logic [DATA_W-1:0] ctlReg, dataReg, addrReg, srcCtl;
  opKind_t           curKind, nextKind;
  logic              accept, dataBusy;
  logic              unusedBits;

  assign unusedBits = ^{regWData[31:16], rxWord[FRAME_BITS-1:RX_TA2+1]};
  assign accept     = regWr && !active;
  assign dataBusy   = active && (curKind != OP_ADDR);
  assign divField   = divReg;

  function automatic logic [FRAME_BITS-1:0] buildFrame(
      input logic c45, input opKind_t k, input logic [4:0] prt,
      input logic [4:0] dev, input logic [DATA_W-1:0] payload);
    logic [1:0] st, op, ta;
    st = c45 ? 2'b00 : 2'b01;
    case (k)
      OP_WRITE: op = 2'b01;
      OP_READ:  op = c45 ? 2'b11 : 2'b10;
      default:  op = 2'b00;
    endcase
    ta = (k == OP_READ) ? 2'b11 : 2'b10;
    return {st, op, prt, dev, ta, payload};
  endfunction

  always_comb begin
    nextKind = OP_NONE;
    if (accept) begin
      case (regAddr)
        W_CTL:   if (regWData[CTL_RD]) nextKind = OP_READ;
        W_DATA:  nextKind = OP_WRITE;
        W_ADDR:  if (encSel) nextKind = OP_ADDR;
        default: nextKind = OP_NONE;
      endcase
    end
    srcCtl       = (nextKind == OP_READ) ? regWData[DATA_W-1:0] : ctlReg;
    cmd.launch   = (nextKind != OP_NONE);
    cmd.isRead   = (nextKind == OP_READ);
    cmd.isAddr   = (nextKind == OP_ADDR);
    cmd.preamble = !srcCtl[CTL_PREOFF];
    cmd.frame    = buildFrame(encSel, nextKind, srcCtl[9:5], srcCtl[4:0],
                              (nextKind == OP_READ) ? '1 : regWData[DATA_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encSel  <= 1'b0;
      rdErr   <= 1'b0;
      divReg  <= '0;
      ctlReg  <= '0;
      dataReg <= '0;
      addrReg <= '0;
      curKind <= OP_NONE;
    end else begin
      if (accept) begin
        case (regAddr)
          W_STAT: begin
            encSel <= regWData[ENC_BIT];
            divReg <= regWData[DIV_LSB +: DIV_W];
          end
          W_CTL:   ctlReg  <= regWData[DATA_W-1:0];
          W_DATA:  dataReg <= regWData[DATA_W-1:0];
          W_ADDR:  addrReg <= regWData[DATA_W-1:0];
          default: ;
        endcase
      end
      if (cmd.launch) curKind <= nextKind;
      if (cmd.isRead) rdErr <= 1'b0;
      if (done) begin
        if (curKind == OP_READ) begin
          dataReg <= rxWord[DATA_W-1:0];
          rdErr   <= rxWord[RX_TA2];
        end
        curKind <= OP_NONE;
      end
    end
  end

  always_comb begin
    regRData = '0;
    case (regAddr)
      W_STAT: begin
        regRData[DIV_LSB +: DIV_W] = divReg;
        regRData[ENC_BIT]          = encSel;
        regRData[RDERR_BIT]        = rdErr;
        regRData[BUSY_BIT]         = active;
      end
      W_CTL:  regRData[DATA_W-1:0] = ctlReg;
      W_DATA: begin
        regRData[DATA_W-1:0] = dataReg;
        regRData[DATA_BUSY]  = dataBusy;
      end
      W_ADDR:  regRData[DATA_W-1:0] = addrReg;
      default: regRData = '0;
    endcase
  end

  // R9: writes during a frame leave configuration untouched
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (active && regWr) |=> ($stable(ctlReg) && $stable(addrReg) && $stable(divReg) && $stable(encSel)));
  // R7: a starting read clears the error flag
  p_rderr_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.launch && cmd.isRead) |=> !rdErr);
  // R8: a start makes the serializer busy next cycle
  p_launch_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.launch |=> active);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic [3:0]    regAddr,
  input  logic [31:0]   regWData,
  output logic [31:0]   regRData,
  output logic          mdc,
  output logic          mdioOut,
  output logic          mdioOe,
  input  logic          mdioIn
);
  mdioCmd_t              cmd;
  logic [DIV_W-1:0]      divField;
  logic                  active, done;
  logic [FRAME_BITS-1:0] rxWord;

  mdio_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .active(active),
    .done(done), .rxWord(rxWord), .cmd(cmd), .divField(divField)
  );

  mdio_dp #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divField(divField),
    .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .active(active), .done(done), .rxWord(rxWord)
  );
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic        clk = 1'b0, rstN = 1'b0, regWr = 1'b0, mdioIn = 1'b1;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWData = '0, regRData;
  logic        mdc, mdioOut, mdioOe;
  int          checks = 0, errors = 0;

  mdio_master u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;   // 50 MHz

  // bus monitor and PHY model
  int      bitIdx = 0;
  logic    obsOut [96];
  logic    obsOe  [96];
  longint  riseT  [96];
  int      respPre = 32;
  logic    respOk = 1'b1;
  logic [15:0] respData = '0;

  function automatic logic respBit(int j);
    int k = j - respPre;
    if (k == 15) return !respOk;
    if (k >= 16 && k < 32) return respOk ? respData[31-k] : 1'b1;
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    if (bitIdx < 96) begin
      obsOut[bitIdx] = mdioOut;
      obsOe[bitIdx]  = mdioOe;
      riseT[bitIdx]  = $time;
    end
    bitIdx++;
  end
  always @(negedge mdc) mdioIn = respBit(bitIdx);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      regRead(4'd12, s);
      if (!s[0]) break;
    end
  endtask

  // kind: 0 write, 1 read, 2 address
  function automatic logic [31:0] expFrame(bit c45, int kind, logic [4:0] prt,
                                           logic [4:0] dev, logic [15:0] d);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (kind == 0) op = 2'b01;
    else if (kind == 1) op = c45 ? 2'b11 : 2'b10;
    else op = 2'b00;
    return {st, op, prt, dev, 2'b10, d};
  endfunction

  task automatic checkFrame(int pre, logic [31:0] fr, bit isRd, int period, string req);
    int mism = 0;
    check(bitIdx == pre + 32, req, bitIdx, pre + 32);
    for (int j = 0; j < pre + 32 && j < 96; j++) begin
      int  k = j - pre;
      logic eOe  = !(isRd && k >= 14);
      logic eBit = (k < 0) ? 1'b1 : fr[31-k];
      if (obsOe[j] !== eOe) mism++;
      else if (eOe && obsOut[j] !== eBit) mism++;
    end
    check(mism == 0, isRd ? {req, "/R6"} : req, mism, 0);
    check((riseT[1] - riseT[0]) == longint'(period) * 20, "R2", 32'(riseT[1] - riseT[0]), period * 20);
  endtask

  task automatic doOp(bit c45, int kind, int div, bit preDis, logic [4:0] prt,
                      logic [4:0] dev, logic [15:0] d, bit ok);
    logic [31:0] s, dr, ctlv;
    int pre = preDis ? 0 : 32;
    regWrite(4'd12, {16'b0, 8'(div), 1'b0, c45, 6'b0});
    ctlv = (32'(preDis) << 10) | (32'(prt) << 5) | 32'(dev);
    regWrite(4'd13, ctlv);
    respPre = pre; respOk = ok; respData = d; bitIdx = 0; mdioIn = 1'b1;
    if (kind == 0) regWrite(4'd14, {16'b0, d});
    else if (kind == 1) regWrite(4'd13, ctlv | 32'h8000);
    else regWrite(4'd15, {16'b0, d});
    if (kind == 2 && !c45) begin
      repeat (20) @(negedge clk);
      check(bitIdx == 0, "R5 no frame", bitIdx, 0);
      regRead(4'd15, s);
      check(s == {16'b0, d}, "R5 addr stored", s, {16'b0, d});
      return;
    end
    repeat (3) @(negedge clk);
    regRead(4'd12, s); regRead(4'd14, dr);
    check(s[0] && (dr[31] == (kind != 2)), "R8 busy", {s[0], dr[31]}, {1'b1, kind != 2});
    if (kind == 1) check(!s[1], "R7 cleared at start", s[1], 0);
    waitIdle();
    checkFrame(pre, expFrame(c45, kind, prt, dev, d), kind == 1,
               (div < 1) ? 4 : 4 * div, c45 ? "R4" : "R3");
    regRead(4'd12, s); regRead(4'd14, dr);
    check(!s[0] && !dr[31], "R8 idle", {s[0], dr[31]}, 0);
    if (kind == 1) begin
      check(dr[15:0] == (ok ? d : 16'hFFFF), "R6 read data", dr[15:0], ok ? d : 16'hFFFF);
      check(s[1] == !ok, "R7 error flag", s[1], !ok);
    end
    if (kind == 0) check(dr[15:0] == d, "R5 data kept", dr[15:0], d);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, v;
    int seed = 32'h5a17;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 12; a < 16; a++) begin
      regRead(4'(a), s);
      check(s == 0, "R1 reg", s, 0);
    end
    check(!mdc && !mdioOe, "R1 pins", {mdc, mdioOe}, 0);

    // R11 map
    regWrite(4'd12, 32'h0000_0340);
    regRead(4'd12, s);
    check(s == 32'h0000_0340, "R11 stat", s, 32'h340);
    regRead(4'd3, s);
    check(s == 0, "R11 hole", s, 0);
    regRead(4'd11, s);
    check(s == 0, "R11 hole", s, 0);

    // R10 stored-only bits
    regWrite(4'd12, 32'h0000_0100);
    regWrite(4'd13, 32'h0000_4800 | (32'd9 << 5) | 32'd3);
    regRead(4'd13, s);
    check(s == (32'h4800 | (32'd9 << 5) | 32'd3), "R10 readback", s, 32'h4923);
    bitIdx = 0; respPre = 32;
    regWrite(4'd14, 32'h0000_BEEF);
    waitIdle();
    checkFrame(32, expFrame(0, 0, 5'd9, 5'd3, 16'hBEEF), 0, 4, "R10");

    // R9 writes during a frame
    regWrite(4'd12, 32'h0000_0000);
    regWrite(4'd13, (32'd1 << 5) | 32'd2);
    bitIdx = 0;
    regWrite(4'd14, 32'h0000_1234);
    repeat (5) @(negedge clk);
    regWrite(4'd14, 32'h0000_5678);
    regWrite(4'd13, 32'h0000_801F);
    regWrite(4'd15, 32'h0000_7777);
    waitIdle();
    regRead(4'd14, s);
    check(s[15:0] == 16'h1234, "R9 data", s, 32'h1234);
    regRead(4'd13, s);
    check(s == 32'h22, "R9 ctl", s, 32'h22);
    check(bitIdx == 64, "R9 single frame", bitIdx, 64);

    // R9 write on the exact completion edge, div=1 -> 256 clocks
    regWrite(4'd12, 32'h0000_0100);
    bitIdx = 0;
    regWrite(4'd14, 32'h0000_AAAA);
    repeat (255) @(negedge clk);
    regRead(4'd12, s);
    check(s[0], "R8 busy before end", s[0], 1);
    regAddr = 4'd14; regWData = 32'h0000_5555; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    regRead(4'd12, s);
    check(!s[0], "R9 same-edge start dropped", s[0], 0);
    regRead(4'd14, v);
    check(v[15:0] == 16'hAAAA, "R9 same-edge data", v, 32'hAAAA);
    repeat (10) @(negedge clk);
    check(bitIdx == 64, "R9 no extra frame", bitIdx, 64);
    regWrite(4'd14, 32'h0000_5555);
    regRead(4'd12, s);
    check(s[0], "R5 accepted next", s[0], 1);
    waitIdle();

    // directed: extended-format address then failed read then good read
    doOp(1, 2, 2, 0, 5'd17, 5'd1, 16'h00A5, 1);
    doOp(1, 1, 0, 0, 5'd17, 5'd1, 16'hC3C3, 0);
    doOp(1, 1, 1, 1, 5'd17, 5'd1, 16'h0F0F, 1);
    doOp(0, 1, 3, 0, 5'd31, 5'd31, 16'hFFFE, 1);

    // random mix
    for (int i = 0; i < 30; i++) begin
      bit c45 = 1'($urandom);
      int kind = $urandom % 3;
      int div = $urandom % 4;
      doOp(c45, kind, div, 1'($urandom), 5'($urandom), 5'($urandom),
           16'($urandom), ($urandom % 4) != 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule